// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer/Counter

This block contains two 16-bit up counters. Each one has its own run bit, its own source select and its own sticky overflow flag. A source select chooses between internal machine cycles and falling edges on an external event pin. A machine cycle is a fixed number of input clocks, 12 by default. A chain bit fuses the two counters into one 32-bit counter. Timer 0 then forms the low half, and its carry feeds timer 1.

Software reaches the block through a plain single-cycle register port. A write takes effect at the next clock edge. The read data is a combinational function of the address. The overflow flags also appear on dedicated output pins, so a neighbouring interrupt block can watch them. There is no streaming data path, so no valid/ready handshake is needed. All pins are plain control and status signals.

When the chain bit is cleared, each counter falls back to its own run bit and source select. A counter whose run bit is still set keeps counting, so a full stop needs the chain bit and both run bits at zero.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both counts, the control register and both overflow flags read zero.
- R2: A running counter that takes machine cycles as its source advances by exactly one for every DIV clock cycles.
- R3: With the chain bit 0, each counter advances only while its own run bit is 1. A counter whose run bit is 0 holds its value, whatever the other counter does.
- R4: With the chain bit 0, a counter that steps from 0xFFFF to 0x0000 sets its own overflow flag.
- R5: With the chain bit 1, timer 0 is the low half and timer 1 the high half of one 32-bit count. A carry out of timer 0 advances timer 1 and never sets overflow flag 0.
- R6: With the chain bit 1, the source select of timer 0 (0 = machine cycles, 1 = external events) drives the 32-bit count. The source select of timer 1 has no effect.
- R7: With the chain bit 1, a step from 0xFFFF_FFFF to zero sets overflow flag 1.
- R8: The chain bit alone starts the 32-bit count, and both run bits are ignored while it is 1. Clearing it returns each counter to its own settings: with both run bits 0 the count halts, and a counter whose run bit is 1 keeps counting.
- R9: In event mode each event pin passes through a two-flop synchronizer and is sampled once per machine cycle. The count advances by one for each sampled transition from 1 to 0. A pin held at a constant level adds nothing.
- R10: The overflow flags stay set until software clears them. A write to address 3 clears flag i when data bit i is 0 and leaves flag i unchanged when bit i is 1. Reading address 3 returns flag 0 in bit 0 and flag 1 in bit 1.
- R11: When a hardware overflow and a software clear of the same flag fall in the same clock cycle, the flag ends up set.
- R12: A write to a count register loads the written value at the next clock edge, overriding any step in that cycle.
- R13: The register map is as follows. Address 0 is count 0 and address 1 is count 1. Address 2 is the control register: bit 0 is run 0, bit 1 is run 1, bit 2 is source 0, bit 3 is source 1 and bit 4 is the chain bit. Address 3 holds the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| ev0_in | input | 1 | External event pin of timer 0, asynchronous |
| ev1_in | input | 1 | External event pin of timer 1, asynchronous |
| ovf0_o | output | 1 | Overflow flag of timer 0 |
| ovf1_o | output | 1 | Overflow flag of timer 1 or of the 32-bit count |

## Verification
The hardest cases to reach from the ports are a software write that lands on exactly the clock edge where the prescaler fires. Two such cases matter: a flag clear that coincides with an overflow, and a count load that coincides with a step. The prescaler phase cannot be read out, so the stimulus first recovers it. It loads 0xFFFF into a running counter and polls the overflow pin until it rises. That edge is a known tick, and every later tick falls a whole number of machine cycles after it. The clear and the load are then timed to land on those ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    REG_CNT0 = 2'd0,
    REG_CNT1 = 2'd1,
    REG_CTRL = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;

  // Control register layout, bit 4 down to bit 0.
  typedef struct packed {
    logic chain;
    logic src1;
    logic src0;
    logic run1;
    logic run0;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/tmr_evsync.sv
module tmr_evsync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ev_in,
  output logic step
);
  logic s1_q, s2_q, smp_q;

  // Falling edge as seen between two machine-cycle samples.
  assign step = tick & smp_q & ~s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      s1_q <= ev_in;
      s2_q <= s1_q;
      if (tick) smp_q <= s2_q;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         wrap
);
  // A load cancels the step and also its carry.
  assign wrap = inc & ~ld & (q == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ev0_in,
  input  logic             ev1_in,
  output logic             ovf0_o,
  output logic             ovf1_o
);
  localparam int NT = 2;

  reg_sel_e   sel;
  tmr_ctrl_t  ctrl_q;
  logic       chain_on;
  logic       tick;
  logic [NT-1:0] ev_in_v, ev_step_v, src_step, ld_v, inc_v, wrap_v, set_v;
  logic [NT-1:0] ovf_q, ovf_d, run_v, srcsel_v;
  logic [CNT_W-1:0] cnt_q [NT];
  logic [CNT_W-1:0] cnt0_q, cnt1_q;
  logic       flag_wr;

  assign sel      = reg_sel_e'(reg_addr);
  assign chain_on = ctrl_q.chain;
  assign ev_in_v  = {ev1_in, ev0_in};
  assign run_v    = {ctrl_q.run1, ctrl_q.run0};
  assign srcsel_v = {ctrl_q.src1, ctrl_q.src0};
  assign flag_wr  = reg_we && (sel == REG_FLAG);

  tmr_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  // Control register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (reg_we && (sel == REG_CTRL))
      ctrl_q <= tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  // Per-timer event sampling, source choice, counter and flag.
  for (genvar g = 0; g < NT; g++) begin : g_tmr
    tmr_evsync u_ev (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .ev_in(ev_in_v[g]),
      .step (ev_step_v[g])
    );

    assign src_step[g] = srcsel_v[g] ? ev_step_v[g] : tick;
    assign ld_v[g]     = reg_we && (reg_addr == 2'(g));

    tmr_count #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_v[g]),
      .ld_val(reg_wdata),
      .inc   (inc_v[g]),
      .q     (cnt_q[g]),
      .wrap  (wrap_v[g])
    );

    // Hardware set dominates a software clear in the same cycle.
    assign ovf_d[g] = set_v[g] | (ovf_q[g] & ~(flag_wr & ~reg_wdata[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q[g] <= 1'b0;
      else        ovf_q[g] <= ovf_d[g];
    end
  end

  // Step routing: independent or fused.
  always_comb begin
    if (chain_on) begin
      inc_v[0] = src_step[0];
      inc_v[1] = wrap_v[0];
      set_v[0] = 1'b0;
      set_v[1] = wrap_v[1];
    end else begin
      inc_v    = run_v & src_step;
      set_v    = wrap_v;
    end
  end

  assign cnt0_q = cnt_q[0];
  assign cnt1_q = cnt_q[1];
  assign ovf0_o = ovf_q[0];
  assign ovf1_o = ovf_q[1];

  always_comb begin
    unique case (sel)
      REG_CNT0: reg_rdata = cnt0_q;
      REG_CNT1: reg_rdata = cnt1_q;
      REG_CTRL: reg_rdata = CNT_W'(ctrl_q);
      default:  reg_rdata = CNT_W'(ovf_q);
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] cnt1,
  input logic         chain_on,
  input logic         ovf0,
  input logic         ovf1
);
  // R12
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == 2'd0) |-> cnt0 == $past(reg_wdata));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we && reg_addr == 2'd0) && cnt0 != $past(cnt0))
      |-> cnt0 == $past(cnt0) + W'(1));

  // R5
  no_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf0) |-> !$past(chain_on));

  // R7
  wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf1) && $past(chain_on))
      |-> ($past(cnt0) == {W{1'b1}} && $past(cnt1) == {W{1'b1}}));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf0) |-> $past(reg_we && reg_addr == 2'd3 && !reg_wdata[0]));
endmodule

bind tmr_pair tmr_pair_chk #(.W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .cnt0     (cnt0_q),
  .cnt1     (cnt1_q),
  .chain_on (chain_on),
  .ovf0     (ovf0_o),
  .ovf1     (ovf1_o)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;
  localparam int DIV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ev0_in = 1'b1;
  logic        ev1_in = 1'b1;
  logic        ovf0_o, ovf1_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_pair #(.DIV(DIV), .CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev0_in(ev0_in),
    .ev1_in(ev1_in), .ovf0_o(ovf0_o), .ovf1_o(ovf1_o)
  );

  // Control bits: 0 run0, 1 run1, 2 src0, 3 src1, 4 chain.
  typedef struct packed {
    logic [4:0]  ctrl;
    logic [15:0] p0;
    logic [15:0] p1;
    logic [7:0]  n;
    logic [15:0] e0;
    logic [15:0] e1;
    logic [1:0]  ef;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'b00001, 16'h0010, 16'h0100, 8'd5, 16'h0015, 16'h0100, 2'b00}, // R2 R3
    '{5'b00010, 16'h0020, 16'hFFFE, 8'd3, 16'h0020, 16'h0001, 2'b10}, // R3 R4
    '{5'b00011, 16'hFFFF, 16'h0005, 8'd2, 16'h0001, 16'h0007, 2'b01}, // R4
    '{5'b00000, 16'h1111, 16'h2222, 8'd4, 16'h1111, 16'h2222, 2'b00}, // R3
    '{5'b10000, 16'hFFFE, 16'h1234, 8'd4, 16'h0002, 16'h1235, 2'b00}, // R5 R8
    '{5'b11000, 16'h00FF, 16'h0000, 8'd3, 16'h0102, 16'h0000, 2'b00}, // R6
    '{5'b10011, 16'hFFFF, 16'hFFFF, 8'd1, 16'h0000, 16'h0000, 2'b10}, // R7 R8
    '{5'b00101, 16'h0050, 16'h0060, 8'd4, 16'h0050, 16'h0060, 2'b00}  // R9
  };

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulses(input int k);
    for (int p = 0; p < k; p++) begin
      ev0_in = 1'b0; ev1_in = 1'b0;
      repeat (3 * DIV) @(negedge clk);
      ev0_in = 1'b1; ev1_in = 1'b1;
      repeat (3 * DIV) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a, b, f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R13: reset state through the register map
    rd(2'd0, a); check("R1 cnt0", 48'(a), 48'h0);
    rd(2'd1, a); check("R1 cnt1", 48'(a), 48'h0);
    rd(2'd2, a); check("R1 R13 ctrl", 48'(a), 48'h0);
    rd(2'd3, a); check("R1 flags", 48'({a, ovf1_o, ovf0_o}), 48'h0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 16'h0);
      wr(2'd0, VECS[i].p0);
      wr(2'd1, VECS[i].p1);
      wr(2'd3, 16'h0);
      wr(2'd2, 16'(VECS[i].ctrl));
      repeat (DIV * int'(VECS[i].n)) @(negedge clk);
      rd(2'd0, a); rd(2'd1, b); rd(2'd3, f);
      check($sformatf("table vec %0d R2-R9", i),
            {a, b, f}, {VECS[i].e0, VECS[i].e1, 14'h0, VECS[i].ef});
    end

    // Prescaler phase alignment via the overflow pin: R10 R11 R12
    wr(2'd2, 16'h0);
    wr(2'd0, 16'hFFFF);
    wr(2'd3, 16'h0);
    wr(2'd2, 16'h0001);
    for (int w = 0; w < 4 * DIV && !ovf0_o; w++) @(negedge clk);
    wr(2'd0, 16'hFFFF);              // lands one edge after the tick
    wr(2'd3, 16'h0003);              // bits of 1 keep the flag
    rd(2'd3, f); check("R10 write-one keeps flag", 48'(f[0]), 48'h1);
    wr(2'd3, 16'h0000);
    rd(2'd3, f); check("R10 write-zero clears flag", 48'(f[0]), 48'h0);
    repeat (DIV - 4) @(negedge clk);
    wr(2'd3, 16'h0000);              // coincides with the wrap
    rd(2'd0, a);
    check("R11 set beats clear", 48'({a, 7'h0, ovf0_o}), 48'h1);
    repeat (DIV - 1) @(negedge clk);
    wr(2'd0, 16'h4000);              // coincides with a step
    rd(2'd0, a); check("R12 load overrides step", 48'(a), 48'h4000);
    repeat (DIV) @(negedge clk);
    rd(2'd0, a); check("R12 counting resumes", 48'(a), 48'h4001);

    // R9: event counting on both timers, individual mode
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h000F);
    pulses(3);
    rd(2'd0, a); rd(2'd1, b);
    check("R9 three falling edges", {16'h0, a, b}, {16'h0, 16'h0003, 16'h0103});

    // R5 R9: event carry across the chained halves
    wr(2'd2, 16'h0);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0007);
    wr(2'd3, 16'h0);
    wr(2'd2, 16'h0014);
    pulses(1);
    rd(2'd0, a); rd(2'd1, b); rd(2'd3, f);
    check("R5 R9 chained event carry", {a, b, f}, {16'h0000, 16'h0008, 16'h0000});

    // R8: release of the chain
    wr(2'd2, 16'h0);
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h0020);
    wr(2'd2, 16'h0012);
    repeat (2 * DIV) @(negedge clk);
    wr(2'd2, 16'h0002);              // chain off, run1 still on
    repeat (3 * DIV - 1) @(negedge clk);
    rd(2'd0, a); rd(2'd1, b);
    check("R8 run1 keeps counting", {16'h0, a, b}, {16'h0, 16'h0012, 16'h0023});
    wr(2'd2, 16'h0010);
    repeat (2 * DIV - 1) @(negedge clk);
    wr(2'd2, 16'h0000);
    rd(2'd0, a); rd(2'd1, b);
    repeat (3 * DIV) @(negedge clk);
    rd(2'd0, f);
    check("R8 halted when all zero", {16'h0, a, f}, {16'h0, a, a});
    rd(2'd1, f);
    check("R8 high half halted", 48'(f), 48'(b));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule